// File: doc/BRIEF.md
# Port Pin Direction and Function-Select Register Block

This block holds the configuration for one 16-pin port. A direction register sets each pin's drive direction. Two function registers, one for the upper pin group and one for the lower, give each pin a mode code. The code picks general-purpose I/O or one of the pin's alternate roles. The upper function register also has a bit that stops the clock pin from driving. From these registers the block produces a per-pin output enable and a per-pin effective function select, which the pad multiplexers use. The direction bits act only on pins whose effective function is general-purpose I/O.

Software reaches the registers over a simple synchronous bus. A write strobe updates the addressed register on the rising clock edge. A read strobe returns the addressed register on `bus_rdata_o` one cycle later. The bus has no data stream and no back-pressure: every access completes in the cycle it is presented.

Two inputs decide how the registers initialise. An asynchronous power-on reset sets every register to its initial value. A separate coded event input reports standby and sleep entries and watchdog-caused power-on resets, and only some of these events restore the initial values. A strap input chooses between expanded and single-chip operation. The strap changes what the top pin's mode codes mean, and it is latched once after power-on.

Top module: `pin_mux_ctrl`

## Requirements
- R1: After power-on reset (`rst_n` low) the direction register reads 0x0000, the upper function register 0x0015, the lower function register 0x5000, and `clk_hiz_o` is 0.
- R2: A read with `bus_rd_i` high at a clock edge returns the addressed register on `bus_rdata_o` after that edge. Address 0 is direction, 1 is upper function, 2 is lower function, and 3 reads as zero. After any edge without a read, `bus_rdata_o` is zero. A write with `bus_wr_i` high takes effect at that edge.
- R3: Bits 9, 7, 5, 3 and 1 of the upper function register always read 0 and ignore writes. Every other bit of the three registers is writable.
- R4: A pin whose effective select is 00 (general-purpose I/O) drives `pin_oe_o[k]` equal to direction bit k, where 1 means output.
- R5: A pin whose effective select is not 00 ignores its direction bit.
- R6: `clk_hiz_o` equals bit 15 of the upper function register: 0 drives the clock pin, 1 puts it in high impedance.
- R7: `init_evt_i` = 1 (hardware standby) or 2 (software standby) at a clock edge restores all three registers to their R1 values at that edge. This takes priority over a write in the same cycle.
- R8: `init_evt_i` = 3 (sleep) or 4 (watchdog power-on reset) leaves all three registers unchanged.
- R9: Mode code fields: pin k (0 to 7) uses lower bits [2k+1:2k]. Pins 8 to 11 use upper bits 0, 2, 4 and 6. Pin 12 uses upper bit 8 and pin 13 uses upper bit 10. Single-bit fields are zero-extended on the left. Pin 14 uses upper [12:11] and pin 15 uses upper [14:13]. For pins 0 to 14, code 01 selects an alternate function with `pin_oe_o` = `alt_oe_i`, and code 10 selects an alternate input with `pin_oe_o` = 0. `pin_sel_o[2k+1:2k]` carries the effective code.
- R10: For pin 15, code 10 is the bus-request input with output enable 0 in expanded mode (strap 0). In single-chip mode (strap 1) it is the chip-select I/O, with `pin_oe_o[15]` = `alt_oe_i[15]`.
- R11: Reserved codes are 11 on pins 0 to 7 and 14, and 01 or 11 on pin 15. A reserved code gives effective select 00 with direction-controlled output enable and raises `rsv_flag_o`. The stored value still reads back.
- R12: `single_chip_i` is latched at the first clock edge after power-on reset. Later changes on it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| init_evt_i | input | 3 | Event code: 0 none, 1 hardware standby, 2 software standby, 3 sleep, 4 watchdog power-on reset |
| single_chip_i | input | 1 | Operating-mode strap: 1 single-chip, 0 expanded |
| bus_addr_i | input | 2 | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, registered |
| alt_oe_i | input | 16 | Output enables requested by alternate peripherals |
| pin_oe_o | output | 16 | Per-pin output enable |
| pin_sel_o | output | 32 | Per-pin effective function code, 2 bits per pin |
| clk_hiz_o | output | 1 | Clock pin high-impedance request |
| rsv_flag_o | output | 1 | Some pin holds a reserved mode code |

## Verification
Register writes and initialisation events take effect at the edge where they are presented. `pin_oe_o`, `pin_sel_o`, `clk_hiz_o` and `rsv_flag_o` are combinational from the registers, so they are due right after that edge. Read data is registered and is due after the edge that samples the read strobe. The bench drives every strobe on a falling edge and samples one falling edge later, so each result is checked half a cycle after the edge that produced it. The strap is due after the first edge following reset release, and the bench waits a few cycles before the first check.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
  localparam int NPIN   = 16;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 2;
  localparam int CODE_W = 2;
  localparam int SEL_W  = NPIN * CODE_W;

  localparam logic [DATA_W-1:0] DIR_INIT  = 16'h0000;
  localparam logic [DATA_W-1:0] FNH_INIT  = 16'h0015;
  localparam logic [DATA_W-1:0] FNL_INIT  = 16'h5000;
  localparam logic [DATA_W-1:0] FNH_WMASK = 16'hFD55;

  localparam logic [ADDR_W-1:0] A_DIR = 2'd0;
  localparam logic [ADDR_W-1:0] A_FNH = 2'd1;
  localparam logic [ADDR_W-1:0] A_FNL = 2'd2;

  typedef enum logic [2:0] {
    EVT_NONE   = 3'd0,
    EVT_HWSTBY = 3'd1,
    EVT_SWSTBY = 3'd2,
    EVT_SLEEP  = 3'd3,
    EVT_WDTPOR = 3'd4
  } init_evt_e;

  typedef enum logic [CODE_W-1:0] {
    SEL_GPIO   = 2'b00,
    SEL_ALT    = 2'b01,
    SEL_ALT_IN = 2'b10,
    SEL_RSV    = 2'b11
  } pin_sel_e;
endpackage

// File: rtl/pmx_regfile.sv
module pmx_regfile
  import pmx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reinit,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] dir_q,
  output logic [DATA_W-1:0] fnh_q,
  output logic [DATA_W-1:0] fnl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= DIR_INIT;
      fnh_q <= FNH_INIT;
      fnl_q <= FNL_INIT;
    end else if (reinit) begin
      dir_q <= DIR_INIT;
      fnh_q <= FNH_INIT;
      fnl_q <= FNL_INIT;
    end else if (wr) begin
      case (addr)
        A_DIR:   dir_q <= wdata;
        A_FNH:   fnh_q <= wdata & FNH_WMASK;
        A_FNL:   fnl_q <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd) begin
      case (addr)
        A_DIR:   rdata <= dir_q;
        A_FNH:   rdata <= fnh_q;
        A_FNL:   rdata <= fnl_q;
        default: rdata <= '0;
      endcase
    end else begin
      rdata <= '0;
    end
  end
endmodule

// File: rtl/pmx_strap.sv
module pmx_strap (
  input  logic clk,
  input  logic rst_n,
  input  logic strap_i,
  output logic strap_q
);
  logic taken_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken_q <= 1'b0;
      strap_q <= 1'b0;
    end else if (!taken_q) begin
      taken_q <= 1'b1;
      strap_q <= strap_i;
    end
  end
endmodule

// File: rtl/pmx_pin_decode.sv
module pmx_pin_decode
  import pmx_pkg::*;
#(
  parameter bit IS_TOP = 1'b0
) (
  input  logic [CODE_W-1:0] code,
  input  logic              dir_bit,
  input  logic              alt_oe,
  input  logic              single_chip,
  output logic              oe,
  output logic [CODE_W-1:0] sel,
  output logic              rsv
);
  always_comb begin
    rsv = 1'b0;
    sel = SEL_GPIO;
    oe  = dir_bit;
    case (code)
      SEL_GPIO: ;
      SEL_ALT: begin
        if (IS_TOP) begin
          rsv = 1'b1;
        end else begin
          sel = SEL_ALT;
          oe  = alt_oe;
        end
      end
      SEL_ALT_IN: begin
        sel = SEL_ALT_IN;
        oe  = (IS_TOP && single_chip) ? alt_oe : 1'b0;
      end
      default: rsv = 1'b1;
    endcase
  end
endmodule

// File: rtl/pin_mux_ctrl.sv
module pin_mux_ctrl
  import pmx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        init_evt_i,
  input  logic              single_chip_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [NPIN-1:0]   alt_oe_i,
  output logic [NPIN-1:0]   pin_oe_o,
  output logic [SEL_W-1:0]  pin_sel_o,
  output logic              clk_hiz_o,
  output logic              rsv_flag_o
);
  logic [DATA_W-1:0] dir_q, fnh_q, fnl_q;
  logic              reinit, strap_q;
  logic [NPIN-1:0]   rsv_pin;

  assign reinit = (init_evt_i == EVT_HWSTBY) || (init_evt_i == EVT_SWSTBY);

  pmx_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .reinit(reinit),
    .addr(bus_addr_i), .wr(bus_wr_i), .rd(bus_rd_i), .wdata(bus_wdata_i),
    .rdata(bus_rdata_o), .dir_q(dir_q), .fnh_q(fnh_q), .fnl_q(fnl_q)
  );

  pmx_strap u_strap (
    .clk(clk), .rst_n(rst_n), .strap_i(single_chip_i), .strap_q(strap_q)
  );

  for (genvar k = 0; k < NPIN; k++) begin : g_pin
    logic [CODE_W-1:0] code;
    if (k < 8) begin : g_lo
      assign code = fnl_q[2*k +: 2];
    end else if (k < 12) begin : g_hi_s
      assign code = {1'b0, fnh_q[2*(k-8)]};
    end else if (k == 12) begin : g_p12
      assign code = {1'b0, fnh_q[8]};
    end else if (k == 13) begin : g_p13
      assign code = {1'b0, fnh_q[10]};
    end else if (k == 14) begin : g_p14
      assign code = fnh_q[12:11];
    end else begin : g_p15
      assign code = fnh_q[14:13];
    end

    pmx_pin_decode #(.IS_TOP(k == NPIN-1)) u_dec (
      .code(code), .dir_bit(dir_q[k]), .alt_oe(alt_oe_i[k]),
      .single_chip(strap_q), .oe(pin_oe_o[k]),
      .sel(pin_sel_o[CODE_W*k +: CODE_W]), .rsv(rsv_pin[k])
    );
  end

  assign clk_hiz_o  = fnh_q[15];
  assign rsv_flag_o = |rsv_pin;
endmodule

// File: rtl/pmx_checker.sv
module pmx_checker
  import pmx_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        init_evt_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_wr_i,
  input logic              bus_rd_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic [NPIN-1:0]   pin_oe_o,
  input logic [SEL_W-1:0]  pin_sel_o,
  input logic              clk_hiz_o
);
  a_r2_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_i |=> bus_rdata_o == '0);

  a_r3_rsv_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_i && bus_addr_i == A_FNH) |=> (bus_rdata_o & ~FNH_WMASK) == '0);

  a_r7_standby_reinit: assert property (@(posedge clk) disable iff (!rst_n)
    (init_evt_i == EVT_HWSTBY || init_evt_i == EVT_SWSTBY) |=> !clk_hiz_o);

  a_r8_sleep_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    ((init_evt_i == EVT_SLEEP || init_evt_i == EVT_WDTPOR) && !bus_wr_i)
      |=> ($stable(clk_hiz_o) && $stable(pin_sel_o)));

  for (genvar k = 0; k < NPIN-1; k++) begin : g_chk
    a_r9_alt_in_no_oe: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_sel_o[2*k +: 2] == SEL_ALT_IN) |-> !pin_oe_o[k]);
  end
endmodule

bind pin_mux_ctrl pmx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .init_evt_i(init_evt_i), .bus_addr_i(bus_addr_i),
  .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i), .bus_rdata_o(bus_rdata_o),
  .pin_oe_o(pin_oe_o), .pin_sel_o(pin_sel_o), .clk_hiz_o(clk_hiz_o)
);

// File: tb/test_pin_mux_ctrl.sv
`timescale 1ns/1ps
module test_pin_mux_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  init_evt_i = 3'd0;
  logic        single_chip_i = 1'b0;
  logic [1:0]  bus_addr_i = 2'd0;
  logic        bus_wr_i = 1'b0;
  logic        bus_rd_i = 1'b0;
  logic [15:0] bus_wdata_i = 16'h0;
  logic [15:0] bus_rdata_o;
  logic [15:0] alt_oe_i = 16'h0;
  logic [15:0] pin_oe_o;
  logic [31:0] pin_sel_o;
  logic        clk_hiz_o, rsv_flag_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pin_mux_ctrl i_pin_mux_ctrl (
    .clk(clk), .rst_n(rst_n), .init_evt_i(init_evt_i), .single_chip_i(single_chip_i),
    .bus_addr_i(bus_addr_i), .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .alt_oe_i(alt_oe_i),
    .pin_oe_o(pin_oe_o), .pin_sel_o(pin_sel_o), .clk_hiz_o(clk_hiz_o),
    .rsv_flag_o(rsv_flag_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
    @(negedge clk);
    bus_wr_i = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr_i = a; bus_rd_i = 1'b1;
    @(negedge clk);
    bus_rd_i = 1'b0;
    d = bus_rdata_o;
  endtask

  task automatic evt(logic [2:0] e);
    @(negedge clk);
    init_evt_i = e;
    @(negedge clk);
    init_evt_i = 3'd0;
  endtask

  task automatic por(logic strap);
    @(negedge clk);
    rst_n = 1'b0; single_chip_i = strap;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // Reference model from the requirements: returns {rsv, sel, oe}
  function automatic logic [48:0] model(logic [15:0] d, logic [15:0] fh,
                                         logic [15:0] fl, logic [15:0] alt, logic sc);
    logic [15:0] oe;
    logic [31:0] sel;
    logic        rsv;
    rsv = 1'b0;
    for (int k = 0; k < 16; k++) begin
      logic [1:0] c;
      if (k < 8)       c = fl[2*k +: 2];
      else if (k < 12) c = {1'b0, fh[2*(k-8)]};
      else if (k == 12) c = {1'b0, fh[8]};
      else if (k == 13) c = {1'b0, fh[10]};
      else if (k == 14) c = fh[12:11];
      else             c = fh[14:13];
      sel[2*k +: 2] = 2'b00;
      oe[k] = d[k];
      if (c == 2'b11 || (k == 15 && c == 2'b01)) begin
        rsv = 1'b1;
      end else if (c == 2'b01) begin
        sel[2*k +: 2] = 2'b01; oe[k] = alt[k];
      end else if (c == 2'b10) begin
        sel[2*k +: 2] = 2'b10; oe[k] = (k == 15 && sc) ? alt[k] : 1'b0;
      end
    end
    return {rsv, sel, oe};
  endfunction

  task automatic sweep(logic sc);
    logic [15:0] dirs [3];
    logic [15:0] alts [3];
    dirs[0] = 16'h0000; dirs[1] = 16'hFFFF; dirs[2] = 16'hA5A5;
    alts[0] = 16'h0000; alts[1] = 16'hFFFF; alts[2] = 16'h5A5A;
    for (int cl = 0; cl < 4; cl++)
      for (int ch = 0; ch < 2; ch++)
        for (int c14 = 0; c14 < 4; c14++)
          for (int c15 = 0; c15 < 4; c15++)
            for (int p = 0; p < 9; p++) begin
              logic [15:0] fl, fh, fhs;
              logic [48:0] m;
              logic b;
              b  = ch[0];
              fl = {8{cl[1:0]}};
              fh = {b, c15[1:0], c14[1:0], b, 1'b1, b, 1'b1, b, 1'b1, b, 1'b1, b, 1'b1, b};
              fhs = fh & 16'hFD55;
              wr(2'd0, dirs[p/3]);
              wr(2'd1, fh);
              wr(2'd2, fl);
              alt_oe_i = alts[p%3];
              #1;
              m = model(dirs[p/3], fhs, fl, alts[p%3], sc);
              check("R4,R5,R9,R10,R11 pin_oe", {16'h0, pin_oe_o}, {16'h0, m[15:0]});
              check("R9,R10,R11 pin_sel", pin_sel_o, m[47:16]);
              check("R11 rsv_flag", {31'h0, rsv_flag_o}, {31'h0, m[48]});
              check("R6 clk_hiz", {31'h0, clk_hiz_o}, {31'h0, b});
            end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] d;
    por(1'b0);
    // R1 reset values
    rd(2'd0, d); check("R1 dir init", {16'h0, d}, 32'h0000);
    rd(2'd1, d); check("R1 fnh init", {16'h0, d}, 32'h0015);
    rd(2'd2, d); check("R1 fnl init", {16'h0, d}, 32'h5000);
    check("R1 clk_hiz init", {31'h0, clk_hiz_o}, 32'h0);
    // R2 address 3 and idle read data
    rd(2'd3, d); check("R2 addr3 reads zero", {16'h0, d}, 32'h0);
    wr(2'd0, 16'hBEEF); rd(2'd0, d); check("R2 write then read", {16'h0, d}, 32'hBEEF);
    @(negedge clk); check("R2 idle rdata", {16'h0, bus_rdata_o}, 32'h0);
    // R3 reserved bits
    wr(2'd1, 16'hFFFF); rd(2'd1, d); check("R3 fnh reserved bits", {16'h0, d}, 32'hFD55);
    wr(2'd2, 16'hFFFF); rd(2'd2, d); check("R3 fnl fully writable", {16'h0, d}, 32'hFFFF);
    // R11 stored reserved code reads back
    wr(2'd1, 16'h6000); rd(2'd1, d); check("R11 reserved code stored", {16'h0, d}, 32'h6000);
    // R8 sleep and watchdog reset keep contents
    wr(2'd0, 16'h1234); wr(2'd1, 16'h8001); wr(2'd2, 16'h0F0F);
    evt(3'd3);
    rd(2'd0, d); check("R8 sleep dir", {16'h0, d}, 32'h1234);
    rd(2'd1, d); check("R8 sleep fnh", {16'h0, d}, 32'h8001);
    rd(2'd2, d); check("R8 sleep fnl", {16'h0, d}, 32'h0F0F);
    evt(3'd4);
    rd(2'd0, d); check("R8 wdt dir", {16'h0, d}, 32'h1234);
    rd(2'd1, d); check("R8 wdt fnh", {16'h0, d}, 32'h8001);
    rd(2'd2, d); check("R8 wdt fnl", {16'h0, d}, 32'h0F0F);
    // R7 hardware and software standby
    evt(3'd1);
    rd(2'd0, d); check("R7 hw dir", {16'h0, d}, 32'h0000);
    rd(2'd1, d); check("R7 hw fnh", {16'h0, d}, 32'h0015);
    rd(2'd2, d); check("R7 hw fnl", {16'h0, d}, 32'h5000);
    wr(2'd0, 16'h1234); wr(2'd1, 16'h8001); wr(2'd2, 16'h0F0F);
    evt(3'd2);
    rd(2'd0, d); check("R7 sw dir", {16'h0, d}, 32'h0000);
    rd(2'd1, d); check("R7 sw fnh", {16'h0, d}, 32'h0015);
    rd(2'd2, d); check("R7 sw fnl", {16'h0, d}, 32'h5000);
    check("R7 clk_hiz after standby", {31'h0, clk_hiz_o}, 32'h0);
    // R7 priority over a same-cycle write
    @(negedge clk);
    bus_addr_i = 2'd0; bus_wdata_i = 16'hFFFF; bus_wr_i = 1'b1; init_evt_i = 3'd1;
    @(negedge clk);
    bus_wr_i = 1'b0; init_evt_i = 3'd0;
    rd(2'd0, d); check("R7 standby beats write", {16'h0, d}, 32'h0000);
    // Expanded-mode sweep
    sweep(1'b0);
    // R12 strap change after latch ignored (expanded latched)
    single_chip_i = 1'b1;
    wr(2'd0, 16'h0000); wr(2'd1, 16'h4000); alt_oe_i = 16'h8000; #1;
    check("R12 strap ignored after latch", {31'h0, pin_oe_o[15]}, 32'h0);
    check("R10 expanded bus request sel", {30'h0, pin_sel_o[31:30]}, 32'h2);
    // Single-chip pass
    por(1'b1);
    sweep(1'b1);
    single_chip_i = 1'b0;
    wr(2'd0, 16'h0000); wr(2'd1, 16'h4000); alt_oe_i = 16'h8000; #1;
    check("R12 single-chip latched", {31'h0, pin_oe_o[15]}, 32'h1);
    check("R10 single-chip chip select sel", {30'h0, pin_sel_o[31:30]}, 32'h2);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule